// File: doc/BRIEF.md
# Sample Word Byte Serializer

This block takes one 16-bit result per converter clock cycle from a sampling pipeline and presents it on an 8-bit output bus after a fixed delay of three converter clock cycles. By default each word goes out as two bytes: the upper byte while the converter clock is high, the lower byte while it is low. A run-time single-byte mode sends only the upper byte once per converter cycle and holds it through the low half. The conversion itself is outside the block; the result arrives as a digital word.

The block runs from one clock at twice the converter rate. A phase flag splits each converter cycle into a high half and a low half, so all logic uses one clock edge. The block also drives out the converter clock it derives from that flag. An active-low output enable releases the bus to high impedance; a pull-up on the board (or in the bench) then holds the lines high. The pipeline keeps moving while the bus is released.

Top module: `adc_byte_fmt`

## Requirements
- R1: In two-byte mode (`single_byte_i` = 0) each converter cycle carries one 16-bit word: bits 15..8 after the edge that starts the high half, then bits 7..0 after the edge that starts the low half.
- R2: In two-byte mode the byte driven during the low half is bits 7..0 of the same word whose bits 15..8 were driven in the preceding high half.
- R3: In single-byte mode (`single_byte_i` = 1) only bits 15..8 are driven, and the bus holds that byte, unchanged, through the low half.
- R4: A word sampled at the start of converter cycle n is driven in cycle n+3, a fixed three-cycle delay.
- R5: While `oe_n_i` is 1 the bus is released to high impedance. The delay pipeline keeps advancing, so words sampled during that time still come out three cycles later.
- R6: Reset clears the pipeline. The bus shows zero during reset and in the first three converter cycles after it.
- R7: The mode is sampled only at the start of a high half. A change of `single_byte_i` in the middle of a word does not affect that word's low byte.
- R8: `adc_clk_o` is 0 in reset and toggles on every `clk2x_i` edge. It is 1 during the high (upper byte) half and 0 during the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Internal clock at twice the converter rate |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sample_i | input | 16 | Conversion result, sampled at the start of each high half |
| single_byte_i | input | 1 | 1 = single-byte mode, 0 = two-byte mode |
| oe_n_i | input | 1 | Active-low output enable; 1 releases the bus |
| adc_clk_o | output | 1 | Derived converter clock, high during the upper-byte half |
| dout_o | output | 8 | Byte bus, high impedance when released |

## Verification
The bench changes the mode between words and also in the middle of a word. A design that sampled the mode on every edge would send the wrong low byte in the mid-word case. In single-byte mode it checks that the low half repeats the upper byte. A design that let the low byte through, or that read the low byte from the already shifted pipeline stage, would show a byte from the wrong word there. It releases the bus for several cycles and then re-enables it. A design that stalled the pipeline while the bus was released would come back with old words. It applies reset twice, the second time in the middle of traffic. Zeros are expected for exactly three cycles, so a pipeline that was one stage too short or too long, or left stale data after reset, shows up.

// File: rtl/adc_byte_fmt_pkg.sv
package adc_byte_fmt_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned HALF_COUNT = WORD_W / BYTE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Upper byte of a converter word.
  function automatic byte_t upper_of(input word_t w);
    return w[WORD_W-1 -: BYTE_W];
  endfunction

  // Lower byte of a converter word.
  function automatic byte_t lower_of(input word_t w);
    return w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/fmt_phase.sv
module fmt_phase (
  input  logic clk,
  input  logic rst_n,
  output logic hi_next
);
  // hi_next = 1: the coming edge opens the upper-byte half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_next <= 1'b1;
    else        hi_next <= ~hi_next;
  end
endmodule

// File: rtl/fmt_delay.sv
module fmt_delay
  import adc_byte_fmt_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  word_t d,
  output word_t q
);
  word_t stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stage[0] <= '0;
        else if (adv) stage[0] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stage[g] <= '0;
        else if (adv) stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/fmt_byte_sel.sv
module fmt_byte_sel
  import adc_byte_fmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hi_next,
  input  word_t word_in,
  input  logic  single_in,
  output logic  mode_q,
  output byte_t byte_q
);
  word_t held_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      held_word <= '0;
      byte_q    <= '0;
    end else if (hi_next) begin
      mode_q    <= single_in;
      held_word <= word_in;
      byte_q    <= upper_of(word_in);
    end else if (!mode_q) begin
      byte_q    <= lower_of(held_word);
    end
  end
endmodule

// File: rtl/adc_byte_fmt.sv
module adc_byte_fmt
  import adc_byte_fmt_pkg::*;
#(
  parameter int unsigned LATENCY = 3
) (
  input  logic              clk2x_i,
  input  logic              rst_n_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              single_byte_i,
  input  logic              oe_n_i,
  output logic              adc_clk_o,
  output logic [BYTE_W-1:0] dout_o
);
  logic  hi_next;
  word_t delayed_word;
  logic  mode_q;
  byte_t out_byte;

  fmt_phase u_phase (
    .clk     (clk2x_i),
    .rst_n   (rst_n_i),
    .hi_next (hi_next)
  );

  fmt_delay #(.DEPTH(LATENCY)) u_delay (
    .clk   (clk2x_i),
    .rst_n (rst_n_i),
    .adv   (hi_next),
    .d     (sample_i),
    .q     (delayed_word)
  );

  fmt_byte_sel u_sel (
    .clk       (clk2x_i),
    .rst_n     (rst_n_i),
    .hi_next   (hi_next),
    .word_in   (delayed_word),
    .single_in (single_byte_i),
    .mode_q    (mode_q),
    .byte_q    (out_byte)
  );

  assign adc_clk_o = ~hi_next;
  assign dout_o    = oe_n_i ? {BYTE_W{1'bz}} : out_byte;
endmodule

// File: rtl/adc_byte_fmt_chk.sv
module adc_byte_fmt_chk
  import adc_byte_fmt_pkg::*;
#(
  parameter int unsigned LATENCY = 3
) (
  input logic  clk,
  input logic  rst_n,
  input word_t sample_i,
  input logic  adc_clk_o,
  input logic  mode_q,
  input byte_t byte_q
);
  logic [3:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  assert_clk_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk_o |=> !adc_clk_o);
  assert_clk_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_clk_o |=> adc_clk_o);
  assert_single_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_clk_o && mode_q) |=> $stable(byte_q));
  assert_mode_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk_o |=> $stable(mode_q));
  assert_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 4'd6) |=> (byte_q == '0));

  if (LATENCY == 3) begin : g_lat3
    assert_hi_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd8 && !adc_clk_o) |=> (byte_q == upper_of($past(sample_i, 7))));
    assert_lo_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd8 && adc_clk_o && !mode_q) |=> (byte_q == lower_of($past(sample_i, 8))));
  end
endmodule

bind adc_byte_fmt adc_byte_fmt_chk #(.LATENCY(LATENCY)) u_chk (
  .clk       (clk2x_i),
  .rst_n     (rst_n_i),
  .sample_i  (sample_i),
  .adc_clk_o (adc_clk_o),
  .mode_q    (mode_q),
  .byte_q    (out_byte)
);

// File: tb/test_adc_byte_fmt.sv
`timescale 1ns/1ps
module test_adc_byte_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample = '0;
  logic        single = 1'b0;
  logic        oe_n = 1'b0;
  logic        adc_clk;
  tri1  [7:0]  dout_w;   // pull-up: a released bus reads 8'hFF

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] hist[$];
  logic [7:0]  exp_byte[$];
  logic        exp_clk[$];
  string       exp_tag[$];

  adc_byte_fmt i_adc_byte_fmt (
    .clk2x_i       (clk),
    .rst_n_i       (rst_n),
    .sample_i      (sample),
    .single_byte_i (single),
    .oe_n_i        (oe_n),
    .adc_clk_o     (adc_clk),
    .dout_o        (dout_w)
  );

  always #5 clk = ~clk;

  // Monitor: pops one expected item per clk2x half and compares.
  always @(negedge clk) begin
    if (exp_byte.size() > 0) begin
      logic [7:0] eb;
      logic       ec;
      string      et;
      eb = exp_byte.pop_front();
      ec = exp_clk.pop_front();
      et = exp_tag.pop_front();
      tests++;
      if (dout_w !== eb) begin
        fails++;
        $display("FAIL %s: bus actual %h expected %h at %0t", et, dout_w, eb, $time);
      end
      tests++;
      if (adc_clk !== ec) begin
        fails++;
        $display("FAIL R8: adc_clk actual %b expected %b at %0t", adc_clk, ec, $time);
      end
    end
  end

  // Driver: one converter cycle; optional mode flip between the halves.
  task automatic drive(input logic [15:0] s, input bit m, input bit oe, input bit flip);
    int n;
    logic [15:0] w;
    @(negedge clk); #1;
    sample = s; single = m; oe_n = oe;
    hist.push_back(s);
    n = hist.size() - 1;
    w = (n >= 3) ? hist[n-3] : 16'h0000;
    exp_byte.push_back(oe ? 8'hFF : w[15:8]);
    exp_clk.push_back(1'b1);
    exp_tag.push_back(oe ? "R5" : (n < 3 ? "R6" : (n == 3 ? "R1" : "R4")));
    exp_byte.push_back(oe ? 8'hFF : (m ? w[15:8] : w[7:0]));
    exp_clk.push_back(1'b0);
    exp_tag.push_back(oe ? "R5" : (flip ? "R7" : (n < 3 ? "R6" : (m ? "R3" : "R2"))));
    @(negedge clk);
    if (flip) begin
      #1 single = ~m;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); @(negedge clk); #1;
    rst_n = 0; oe_n = 0;
    hist.delete();
    repeat (3) @(negedge clk);
    tests++;
    if (dout_w !== 8'h00 || adc_clk !== 1'b0) begin
      fails++;
      $display("FAIL R6: in reset bus %h clk %b expected 00 0", dout_w, adc_clk);
    end
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 R2 R4 R6: two-byte traffic with distinct byte patterns
    drive(16'hA15C, 0, 0, 0);
    drive(16'h3C96, 0, 0, 0);
    drive(16'hFF00, 0, 0, 0);
    drive(16'h00FF, 0, 0, 0);
    drive(16'h1234, 0, 0, 0);
    drive(16'hBEEF, 0, 0, 0);
    drive(16'h8001, 0, 0, 0);
    // R3: single-byte mode
    drive(16'h5A5A, 1, 0, 0);
    drive(16'hC3E7, 1, 0, 0);
    drive(16'h0F0F, 1, 0, 0);
    drive(16'h7E81, 1, 0, 0);
    // R7: switch each word and flip mid-word
    drive(16'h2468, 0, 0, 1);
    drive(16'h1357, 1, 0, 1);
    drive(16'h9ABC, 0, 0, 0);
    drive(16'hDEF0, 1, 0, 0);
    drive(16'h4455, 0, 0, 1);
    // R5: bus released, pipeline keeps moving
    drive(16'h6677, 0, 1, 0);
    drive(16'h8899, 0, 1, 0);
    drive(16'hAABB, 1, 1, 0);
    drive(16'hCCDD, 0, 0, 0);
    drive(16'hEE11, 0, 0, 0);
    drive(16'h2233, 0, 0, 0);
    drive(16'h0000, 0, 0, 0);
    // R6: reset in the middle of traffic clears the pipeline
    do_reset();
    drive(16'hF00D, 0, 0, 0);
    drive(16'hCAFE, 0, 0, 0);
    drive(16'hD00D, 1, 0, 0);
    drive(16'h7A7A, 0, 0, 0);
    drive(16'h1111, 0, 0, 0);
    drive(16'h2222, 0, 0, 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule